// File: doc/BRIEF.md
# Backup Power Rail Switchover Controller

This block chooses the source of a protected supply rail, which feeds retained memory or always-on logic. The rail is fed either from the main supply or from a backup battery. It also produces an active-low power-fail warning. Its inputs are four asynchronous comparator flags, supplied by analog circuitry outside the block:
- main supply below the switchover threshold;
- main supply below the battery voltage;
- main supply below the reset threshold;
- power-fail input below its 1.25 V reference.

Each flag is resynchronised through two flops. A flag is then filtered, so that a change takes effect only after it has persisted for `PERSIST` clock cycles.

The switchover logic is deliberately asymmetric. Moving the rail to the battery needs two conditions at once: the main supply is under the switchover threshold and also under the battery. Moving the rail back to mains depends on only one thing: the main supply climbing back over the reset threshold. The battery level is not considered on the way back. Because the reset-threshold flag is shared with the reset controller, the rail is back on mains before that controller's reset timeout begins to run. The power-fail warning is forced active whenever the main supply is under the switchover threshold, since the comparator is treated as unpowered there.

Top module: `bkup_rail_ctrl`

## Requirements
- R1: While `rst_n` is low, `rail_batt_o` is 0 (mains), `mode_o` is 2'b01, and `pfail_n_o` is 0.
- R2: The rail moves to the battery (`rail_batt_o` = 1) only when the filtered below-switch and below-battery flags are both 1. The latency from a raw flag change to the output is `PERSIST`+3 clock cycles, which is 7 with the defaults.
- R3: In mains mode, a single condition on its own never selects the battery. This holds for the below-battery flag alone (battery higher than mains) and for the below-switch flag alone.
- R4: In battery mode, clearing the below-reset flag returns the rail to mains after exactly `PERSIST`+3 cycles, whatever the below-battery flag is. No timeout is inserted.
- R5: In battery mode, the rail stays on the battery while the below-reset flag is 1, even if the below-switch and below-battery flags have cleared.
- R6: `pfail_n_o` is 0 when the filtered power-fail flag or the filtered below-switch flag is 1, and 1 otherwise. It follows its inputs with the same `PERSIST`+3 latency.
- R7: A raw flag change that lasts fewer than `PERSIST` cycles has no effect on `rail_batt_o` or `pfail_n_o`.
- R8: `mode_o` is 2'b01 in mains mode and 2'b10 in battery mode. It always agrees with `rail_batt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| sup_below_sw_i | input | 1 | Raw flag: main supply under switchover threshold |
| sup_below_bat_i | input | 1 | Raw flag: main supply under battery voltage |
| sup_below_rst_i | input | 1 | Raw flag: main supply under reset threshold |
| pfi_below_ref_i | input | 1 | Raw flag: power-fail input under its reference |
| rail_batt_o | output | 1 | Rail source select: 0 mains, 1 battery |
| pfail_n_o | output | 1 | Power-fail warning, active low |
| mode_o | output | 2 | Mode status: 2'b01 mains, 2'b10 battery |

## Verification
The switchover is driven with each entry condition on its own and then with both together. This separates a correct AND from an OR, or from a design that looks at only one flag. The return path clears the reset flag while the below-battery flag is still held high, which shows that the battery level plays no part in exit. Holding the reset flag high after the other flags clear shows the hysteresis band. Exact-cycle latency checks and short glitches on the raw flags separate a working persistence filter from one that is missing or off by one.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    MODE_MAINS = 2'b01,
    MODE_BATT  = 2'b10
  } rail_mode_t;

  localparam int FLAG_N   = 4;
  localparam int F_SW     = 0;
  localparam int F_BAT    = 1;
  localparam int F_RST    = 2;
  localparam int F_PFI    = 3;

  // Entry into battery mode needs both conditions together.
  function automatic logic enter_batt(input logic below_sw, input logic below_bat);
    return below_sw & below_bat;
  endfunction

  // Exit from battery mode depends on the reset threshold only.
  function automatic logic leave_batt(input logic below_rst);
    return ~below_rst;
  endfunction

  // Warning level: high only when the supply is usable and the input is healthy.
  function automatic logic pfail_level(input logic pfi_low, input logic below_sw);
    return ~(pfi_low | below_sw);
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/flag_persist.sv
module flag_persist #(
  parameter int PERSIST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic filt_o
);

  localparam int CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERSIST - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;
  logic          differ;
  logic          accept;

  assign differ = sync_i ^ filt_q;
  assign accept = differ && (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (!differ) begin
      cnt_q  <= '0;
    end else if (accept) begin
      cnt_q  <= '0;
      filt_q <= sync_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R7: the filtered flag moves only after the synced value has differed for PERSIST cycles
  p_filter_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != sync_i) && (cnt_q != LIMIT) |=> $stable(filt_q));

endmodule

// File: rtl/rail_fsm.sv
module rail_fsm
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_sw,
  input  logic       below_bat,
  input  logic       below_rst,
  output logic       rail_batt,
  output rail_mode_t mode
);

  rail_mode_t state_q, state_d;
  logic       go_batt;
  logic       go_mains;

  assign go_batt  = (state_q == MODE_MAINS) && enter_batt(below_sw, below_bat);
  assign go_mains = (state_q == MODE_BATT)  && leave_batt(below_rst);

  always_comb begin
    state_d = state_q;
    if (go_batt)       state_d = MODE_BATT;
    else if (go_mains) state_d = MODE_MAINS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_MAINS;
    else        state_q <= state_d;
  end

  assign rail_batt = (state_q == MODE_BATT);
  assign mode      = state_q;

  // R2: battery entered only when both conditions held in the evaluating cycle
  p_entry_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_batt && !(below_sw && below_bat) |=> !rail_batt);

  // R3: the battery flag alone never moves the rail off mains
  p_bat_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_batt && !below_sw |=> !rail_batt);

  // R4: return to mains as soon as the reset flag clears
  p_exit_on_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rail_batt && !below_rst |=> !rail_batt);

  // R5: hold battery mode while under the reset threshold
  p_hold_batt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rail_batt && below_rst |=> rail_batt);

endmodule

// File: rtl/pfail_gate.sv
module pfail_gate
  import supv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pfi_low,
  input  logic below_sw,
  output logic pfail_n
);

  logic pfail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfail_q <= 1'b0;
    else        pfail_q <= pfail_level(pfi_low, below_sw);
  end

  assign pfail_n = pfail_q;

  // R6: comparator forced off under the switchover threshold
  p_forced_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    below_sw |=> !pfail_n);

  // R6: warning follows the power-fail flag when the supply is usable
  p_follow_pfi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !below_sw |=> (pfail_n == !$past(pfi_low)));

endmodule

// File: rtl/bkup_rail_ctrl.sv
module bkup_rail_ctrl
  import supv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PERSIST     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_below_sw_i,
  input  logic       sup_below_bat_i,
  input  logic       sup_below_rst_i,
  input  logic       pfi_below_ref_i,
  output logic       rail_batt_o,
  output logic       pfail_n_o,
  output logic [1:0] mode_o
);

  logic [FLAG_N-1:0] raw_flags;
  logic [FLAG_N-1:0] sync_flags;
  logic [FLAG_N-1:0] filt_flags;
  rail_mode_t        mode_w;

  assign raw_flags[F_SW]  = sup_below_sw_i;
  assign raw_flags[F_BAT] = sup_below_bat_i;
  assign raw_flags[F_RST] = sup_below_rst_i;
  assign raw_flags[F_PFI] = pfi_below_ref_i;

  flag_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_flags),
    .sync_o (sync_flags)
  );

  for (genvar f = 0; f < FLAG_N; f++) begin : g_persist
    flag_persist #(.PERSIST(PERSIST)) u_persist (
      .clk   (clk),
      .rst_n (rst_n),
      .sync_i(sync_flags[f]),
      .filt_o(filt_flags[f])
    );
  end

  rail_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .below_sw (filt_flags[F_SW]),
    .below_bat(filt_flags[F_BAT]),
    .below_rst(filt_flags[F_RST]),
    .rail_batt(rail_batt_o),
    .mode     (mode_w)
  );

  pfail_gate u_pfail (
    .clk     (clk),
    .rst_n   (rst_n),
    .pfi_low (filt_flags[F_PFI]),
    .below_sw(filt_flags[F_SW]),
    .pfail_n (pfail_n_o)
  );

  assign mode_o = mode_w;

  // R8: status is one-hot and agrees with the rail select
  p_mode_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mode_o) == 1) && (mode_o[1] == rail_batt_o));

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_reset_state_r1: assert (!rail_batt_o && !pfail_n_o);
    end
  end

endmodule

// File: tb/test_bkup_rail_ctrl.sv
module test_bkup_rail_ctrl;

  localparam int PERSIST = 4;
  localparam int LAT     = PERSIST + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw = 1'b0, bat = 1'b0, rstf = 1'b0, pfi = 1'b0;
  logic       rail_batt;
  logic       pfail_n;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bkup_rail_ctrl #(.SYNC_STAGES(2), .PERSIST(PERSIST)) i_bkup_rail_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .sup_below_sw_i (sw),
    .sup_below_bat_i(bat),
    .sup_below_rst_i(rstf),
    .pfi_below_ref_i(pfi),
    .rail_batt_o    (rail_batt),
    .pfail_n_o      (pfail_n),
    .mode_o         (mode)
  );

  task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic b, input logic r, input logic p);
    sw = s; bat = b; rstf = r; pfi = p;
  endtask

  task automatic expect_state(input string req, input logic exp_batt, input logic exp_pf);
    chk(req, "rail", {1'b0, rail_batt}, {1'b0, exp_batt});
    chk(req, "mode", mode, exp_batt ? 2'b10 : 2'b01);
    chk(req, "pfail_n", {1'b0, pfail_n}, {1'b0, exp_pf});
  endtask

  task automatic t_reset;
    step(3);
    expect_state("R1", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(LAT + 2);
    expect_state("R6", 1'b0, 1'b1);
  endtask

  task automatic t_single_conditions;
    drive(0, 1, 0, 0);
    step(LAT + 3);
    expect_state("R3", 1'b0, 1'b1);
    drive(1, 0, 1, 0);
    step(LAT + 3);
    expect_state("R3", 1'b0, 1'b0);
    drive(0, 0, 0, 0);
    step(LAT + 3);
    expect_state("R6", 1'b0, 1'b1);
  endtask

  task automatic t_enter_batt;
    drive(1, 1, 1, 0);
    step(LAT - 1);
    chk("R2", "rail before latency", {1'b0, rail_batt}, 2'b00);
    step(1);
    chk("R2", "rail at latency", {1'b0, rail_batt}, 2'b01);
    chk("R8", "mode battery", mode, 2'b10);
    chk("R6", "pfail forced low", {1'b0, pfail_n}, 2'b00);
  endtask

  task automatic t_hysteresis;
    drive(0, 0, 1, 0);
    step(LAT + 3);
    expect_state("R5", 1'b1, 1'b1);
    drive(0, 0, 1, 1);
    step(LAT + 3);
    expect_state("R6", 1'b1, 1'b0);
    drive(0, 0, 0, 1);
    step(2);
    drive(0, 0, 1, 0);
    step(LAT + 3);
    expect_state("R7", 1'b1, 1'b1);
  endtask

  task automatic t_exit;
    drive(0, 1, 0, 0);
    step(LAT - 1);
    chk("R4", "rail before latency", {1'b0, rail_batt}, 2'b01);
    step(1);
    chk("R4", "rail at latency", {1'b0, rail_batt}, 2'b00);
    chk("R8", "mode mains", mode, 2'b01);
    step(LAT);
    drive(0, 0, 0, 0);
    step(LAT + 3);
  endtask

  task automatic t_glitch;
    drive(1, 1, 1, 1);
    step(PERSIST - 1);
    drive(0, 0, 0, 0);
    for (int i = 0; i < LAT + 3; i++) begin
      step(1);
      chk("R7", "rail during glitch", {1'b0, rail_batt}, 2'b00);
      chk("R7", "pfail during glitch", {1'b0, pfail_n}, 2'b01);
    end
  endtask

  task automatic t_pfi_only;
    drive(0, 0, 0, 1);
    step(LAT);
    expect_state("R6", 1'b0, 1'b0);
    drive(0, 0, 0, 0);
    step(LAT);
    expect_state("R6", 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_single_conditions();
    t_enter_batt();
    t_hysteresis();
    t_exit();
    t_glitch();
    t_pfi_only();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule